// File: doc/BRIEF.md
# Dual-Modulus Swallow Divider

This block is the feedback divider of one frequency-synthesizer channel that drives an external two-ratio prescaler. A strobe marks each output period of the prescaler, which is each rising edge of the prescaled oscillator. A 10-bit main down-counter and a 7-bit swallow down-counter advance on that strobe. The block also drives a modulus-select line back to the prescaler and produces one divided pulse per full count cycle for the phase comparator.

At the start of a cycle the modulus line is low, so the prescaler divides by P+1. It stays low until the swallow counter has run down from its programmed value A. The line then goes high, so the prescaler divides by P, and it stays high for the remaining N−A strobes until the main counter ends its cycle. Both counters then reload and the sequence repeats. The overall division from oscillator to divided pulse is N·P + A.

The programmed ratios come from a one-bit serial shift path and a load strobe. A frame that is accepted updates holding registers. The counters pick up the new values only at their next reload, so a cycle already in progress always finishes with its old ratio.

Top module: `dmod_divider`

## Requirements
- R1: While rst_n is low, mod_ctl and div_pulse are 0 and the counters hold the default ratio (N=10, A=4). The first cycle after reset lasts 10 strobes.
- R2: div_pulse is high for exactly one clock, in the clock after the rising edge that samples the N-th fv_tick of a cycle.
- R3: After a reload with A>0, mod_ctl is low for the first A strobes of the cycle and high for the other N−A. Each change appears one clock after the edge that samples the strobe.
- R4: When fv_tick is produced by a prescaler that divides by P while mod_ctl is high and by P+1 while it is low, the spacing between div_pulse pulses is N·P + A input clocks.
- R5: With A=0, mod_ctl is high for the whole cycle, including the clock right after the reload.
- R6: With A=N, mod_ctl stays low for the whole cycle.
- R7: Each clock with ser_shift high shifts ser_bit into a 17-bit frame, MSB first. Frame bits 16..7 carry N and bits 6..0 carry A, so the last bit shifted is A bit 0. A clock with ser_load high copies the frame (as it stood before that edge) into the holding registers.
- R8: Loaded values take effect only at the next reload. The cycle in progress finishes with the old N and A.
- R9: A loaded frame with N < 3 or A > N is discarded, and the previous ratio stays in force.
- R10: A clock with fv_tick low changes neither the counters nor mod_ctl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| ser_shift | input | 1 | Shift enable for the serial frame |
| ser_bit | input | 1 | Serial data bit, MSB first |
| ser_load | input | 1 | Transfer strobe from frame to holding registers |
| fv_tick | input | 1 | One-clock strobe per prescaler output period |
| mod_ctl | output | 1 | Modulus select to prescaler: 1 selects P, 0 selects P+1 |
| div_pulse | output | 1 | One-clock pulse at the end of each divide cycle |

## Verification
Both outputs are registered. mod_ctl and div_pulse therefore reflect a sampled fv_tick one clock later, and a holding-register update from ser_load shows in the outputs only after the next reload, which is N strobes or fewer away. The bench drives all inputs just after the falling edge and advances an integer position model by one rising edge. At the following falling edge it compares both outputs with that model. This means every expected value is due exactly one edge after its stimulus. The ratio check instead counts whole clocks between successive pulses while a closed-loop prescaler model reacts to mod_ctl. It skips the first, partial interval.

// File: rtl/dmod_pkg.sv
package dmod_pkg;
  localparam int unsigned DM_NW     = 10;
  localparam int unsigned DM_AW     = 7;
  localparam int unsigned DM_MIN_N  = 3;
  localparam int unsigned DM_DEF_N  = 10;
  localparam int unsigned DM_DEF_A  = 4;
endpackage

// File: rtl/dmod_frame_shifter.sv
module dmod_frame_shifter #(
  parameter int unsigned FW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [FW-1:0] frame
);
  logic [FW-1:0] sreg_q;
  logic [FW-1:0] sreg_d;

  // each stage takes its lower neighbour, stage 0 takes the serial bit
  for (genvar i = 0; i < FW; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_comb sreg_d[i] = shift_en ? bit_in : sreg_q[i];
    end else begin : g_body
      always_comb sreg_d[i] = shift_en ? sreg_q[i-1] : sreg_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_d;
  end

  assign frame = sreg_q;

  // R7
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sreg_q));
endmodule

// File: rtl/dmod_ratio_latch.sv
module dmod_ratio_latch
  import dmod_pkg::*;
#(
  parameter int unsigned NW    = DM_NW,
  parameter int unsigned AW    = DM_AW,
  parameter int unsigned MIN_N = DM_MIN_N,
  parameter int unsigned DEF_N = DM_DEF_N,
  parameter int unsigned DEF_A = DM_DEF_A,
  localparam int unsigned FW   = NW + AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [FW-1:0] frame,
  output logic [NW-1:0] n_val,
  output logic [AW-1:0] a_val
);
  logic [NW-1:0] fr_n;
  logic [AW-1:0] fr_a;
  logic          fr_ok;
  logic [NW-1:0] n_q, n_d;
  logic [AW-1:0] a_q, a_d;

  assign fr_n  = frame[FW-1:AW];
  assign fr_a  = frame[AW-1:0];
  assign fr_ok = (fr_n >= NW'(MIN_N)) && (NW'(fr_a) <= fr_n);

  always_comb begin
    n_d = n_q;
    a_d = a_q;
    if (load_en && fr_ok) begin
      n_d = fr_n;
      a_d = fr_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= NW'(DEF_N);
      a_q <= AW'(DEF_A);
    end else begin
      n_q <= n_d;
      a_q <= a_d;
    end
  end

  assign n_val = n_q;
  assign a_val = a_q;

  // R9
  reject_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && ((frame[FW-1:AW] < NW'(MIN_N)) || (NW'(frame[AW-1:0]) > frame[FW-1:AW])))
      |=> ($stable(n_q) && $stable(a_q)));
  // R9
  n_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_q >= NW'(MIN_N)) && (NW'(a_q) <= n_q));
endmodule

// File: rtl/dmod_swallow_core.sv
module dmod_swallow_core
  import dmod_pkg::*;
#(
  parameter int unsigned NW    = DM_NW,
  parameter int unsigned AW    = DM_AW,
  parameter int unsigned DEF_N = DM_DEF_N,
  parameter int unsigned DEF_A = DM_DEF_A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [NW-1:0] ld_n,
  input  logic [AW-1:0] ld_a,
  output logic          mod_ctl,
  output logic          div_pulse
);
  logic [NW-1:0] main_q, main_d;
  logic [AW-1:0] swal_q, swal_d;
  logic          mod_q, mod_d;
  logic          pls_q, pls_d;
  logic          term;

  assign term = (main_q == NW'(1));

  always_comb begin
    main_d = main_q;
    swal_d = swal_q;
    mod_d  = mod_q;
    pls_d  = 1'b0;
    if (tick) begin
      if (term) begin
        main_d = ld_n;
        swal_d = ld_a;
        mod_d  = (ld_a == '0);
        pls_d  = 1'b1;
      end else begin
        main_d = main_q - NW'(1);
        if (swal_q != '0) swal_d = swal_q - AW'(1);
        mod_d  = (swal_q <= AW'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= NW'(DEF_N);
      swal_q <= AW'(DEF_A);
      mod_q  <= 1'b0;
      pls_q  <= 1'b0;
    end else begin
      main_q <= main_d;
      swal_q <= swal_d;
      mod_q  <= mod_d;
      pls_q  <= pls_d;
    end
  end

  assign mod_ctl   = mod_q;
  assign div_pulse = pls_q;

  // R2
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_q != '0);
  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pls_q |=> !pls_q);
  // R3
  mod_low_swallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swal_q != '0) |-> !mod_q);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(main_q) && $stable(swal_q) && $stable(mod_q)));
endmodule

// File: rtl/dmod_divider.sv
module dmod_divider
  import dmod_pkg::*;
#(
  parameter int unsigned NW    = DM_NW,
  parameter int unsigned AW    = DM_AW,
  parameter int unsigned MIN_N = DM_MIN_N,
  parameter int unsigned DEF_N = DM_DEF_N,
  parameter int unsigned DEF_A = DM_DEF_A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_shift,
  input  logic ser_bit,
  input  logic ser_load,
  input  logic fv_tick,
  output logic mod_ctl,
  output logic div_pulse
);
  localparam int unsigned FW = NW + AW;

  logic [FW-1:0] frame;
  logic [NW-1:0] n_val;
  logic [AW-1:0] a_val;

  dmod_frame_shifter #(.FW(FW)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(ser_shift), .bit_in(ser_bit),
    .frame(frame)
  );

  dmod_ratio_latch #(.NW(NW), .AW(AW), .MIN_N(MIN_N), .DEF_N(DEF_N),
                     .DEF_A(DEF_A)) u_latch (
    .clk(clk), .rst_n(rst_n), .load_en(ser_load), .frame(frame),
    .n_val(n_val), .a_val(a_val)
  );

  dmod_swallow_core #(.NW(NW), .AW(AW), .DEF_N(DEF_N), .DEF_A(DEF_A)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(fv_tick), .ld_n(n_val), .ld_a(a_val),
    .mod_ctl(mod_ctl), .div_pulse(div_pulse)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!mod_ctl && !div_pulse));
endmodule

// File: tb/dmod_divider_bench.sv
module dmod_divider_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_shift = 1'b0, ser_bit = 1'b0, ser_load = 1'b0, fv_tick = 1'b0;
  logic mod_ctl, div_pulse;

  always #5 clk = ~clk;

  dmod_divider u_dmod_divider (
    .clk(clk), .rst_n(rst_n), .ser_shift(ser_shift), .ser_bit(ser_bit),
    .ser_load(ser_load), .fv_tick(fv_tick), .mod_ctl(mod_ctl),
    .div_pulse(div_pulse)
  );

  int tests = 0, fails = 0;
  int m_pos = 0, m_n = 10, m_a = 4, lat_n = 10, lat_a = 4, m_sr = 0;
  bit e_mod = 0, e_pulse = 0;
  string tag = "R2";
  int mode = 0, div_k = 1, psc = 0, cyc = 0;
  localparam int P = 8;
  bit rat_on = 0; int rat_seen = 0, rat_last = 0, rat_exp = 0;

  task automatic chk(string t, int got, int exp, string what);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", t, what, got, exp);
    end
  endtask

  function automatic string mod_tag();
    if (m_a == 0) return "R5";
    if (m_a == m_n) return "R6";
    return (tag == "R2") ? "R3" : tag;
  endfunction

  task automatic step(bit tk, bit sh, bit bt, bit ld);
    int fn, fa;
    e_pulse = 0;
    if (tk) begin
      m_pos++;
      if (m_pos == m_n) begin
        m_pos = 0; m_n = lat_n; m_a = lat_a; e_pulse = 1;
      end
      e_mod = (m_pos >= m_a);
    end
    if (ld) begin
      fn = m_sr >> 7; fa = m_sr & 127;
      if (fn >= 3 && fa <= fn) begin lat_n = fn; lat_a = fa; end
    end
    if (sh) m_sr = ((m_sr << 1) | int'(bt)) & 32'h1ffff;
  endtask

  task automatic run_cyc(bit sh, bit bt, bit ld);
    bit tk;
    int lim;
    @(negedge clk);
    cyc++;
    chk(mod_tag(), int'(mod_ctl), int'(e_mod), "mod_ctl");
    chk(tag, int'(div_pulse), int'(e_pulse), "div_pulse");
    if (rat_on && div_pulse) begin
      if (rat_seen >= 1) chk("R4", cyc - rat_last, rat_exp, "pulse spacing");
      rat_seen++; rat_last = cyc;
    end
    case (mode)
      0: tk = 1'b1;
      1: tk = ((cyc % div_k) == 0);
      2: tk = (($urandom % 10) < 3);
      default: begin
        lim = mod_ctl ? P : P + 1;
        tk = (psc == lim - 1);
        psc = tk ? 0 : psc + 1;
      end
    endcase
    fv_tick = tk; ser_shift = sh; ser_bit = bt; ser_load = ld;
    step(tk, sh, bt, ld);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) run_cyc(1'b0, 1'b0, 1'b0);
  endtask

  task automatic send(int n, int a);
    int fr;
    fr = (n << 7) | (a & 127);
    for (int i = 16; i >= 0; i--) run_cyc(1'b1, fr[i], 1'b0);
    run_cyc(1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet outputs in reset
    chk("R1", int'(mod_ctl), 0, "mod_ctl in reset");
    chk("R1", int'(div_pulse), 0, "div_pulse in reset");
    rst_n = 1'b1;
    tag = "R2"; mode = 0; idle(45);
    tag = "R10"; mode = 1; div_k = 2; idle(50);
    tag = "R7"; mode = 0; send(6, 2); idle(30);
    tag = "R8"; send(9, 3); idle(40);
    tag = "R5"; send(4, 0); idle(30);
    tag = "R6"; send(5, 5); idle(30);
    tag = "R9"; send(2, 0); idle(20); send(8, 9); idle(30);
    tag = "R10"; send(130, 127); mode = 2; idle(1200);
    tag = "R2"; mode = 0; send(3, 0); idle(20);
    send(20, 5); idle(30);
    tag = "R4"; mode = 3; psc = 0; rat_exp = 20 * P + 5; rat_on = 1; rat_seen = 0;
    idle(900);
    chk("R4", (rat_seen >= 3) ? 1 : 0, 1, "enough ratio intervals");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R2 watchdog got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule